// File: doc/BRIEF.md
# Receive Buffer Flow-Control Credit Tracker

This block keeps, for each of several receive flow-control groups, a running count of the free receive buffers that software has handed to a receive DMA channel. Software adds credits by writing an amount to the group's allocation register. The DMA engine removes one credit per buffer it fills by pulsing the group's consume input. From that count and two software-set thresholds, each group derives a pause level for its upstream source. The level turns on when the count drops under the low threshold and turns off when the count reaches the high threshold. Between the two it keeps its last value, which gives hysteresis. Software usually places the thresholds at one third and two thirds of the ring size.

Register access is a plain single-cycle write strobe with a byte address and a 32-bit word. There is no read path; the per-group credit counts are exported as status pins. A force bit in the allocation register parks a group: its count is pinned at zero and its pause is suppressed while the channel is torn down. A global configuration word holds a controller-wide enable and one flow-control enable per group.

Top module: `rx_fc_credit_tracker`

## Requirements
- R1: After reset every credit count is 0, every pause output is 0, the force state is clear, the thresholds are 0 and all enables are 0.
- R2: Address map: the configuration word is at byte 0x00, with bit 0 as controller enable and bit g+1 as flow-control enable of group g. Group g has its low threshold at 0x04+12g, its high threshold at 0x08+12g and its allocation register at 0x0C+12g. A write changes only the register it addresses.
- R3: A write to an allocation register with bit 31 clear adds bits [15:0] of the data to that group's credit count. The new count is visible after the next rising edge.
- R4: The credit count saturates at 2^CNT_W-1 (255 by default) and never wraps.
- R5: A consume pulse lowers the count by one. A consume pulse while the count is 0 and no credits are added in the same cycle is ignored.
- R6: An allocation write and a consume pulse in the same cycle give count + amount - 1, saturated.
- R7: The internal pause state sets when the updated count is below the low threshold. It clears when the updated count is at or above the high threshold. Otherwise it holds. If both conditions are true, set wins. Thresholds take part one cycle after they are written.
- R8: A write to an allocation register with bit 31 set forces that group: the count becomes and stays 0, the pause state is 0, and consume pulses and further forced writes leave it there. A write with bit 31 clear releases the force and adds its amount.
- R9: A pause output is high only when the internal pause state, the controller enable and the group's flow-control enable are all high. Clearing an enable does not disturb the count or the pause state.
- R10: While the controller enable is 0, consume pulses are ignored. Allocation writes still add credits.
- R11: Groups are independent: writes and consume pulses for one group do not change any other group's count or pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| consume | input | NUM_GRP | One-cycle pulse per group: one buffer filled |
| pause | output | NUM_GRP | Pause level per group toward the upstream source |
| credits | output | NUM_GRP*CNT_W | Credit count per group, group g in bits [g*CNT_W +: CNT_W] |

## Verification
Every register write and consume pulse takes effect at the next rising edge. The counts and the pause outputs are registered, so each result is due exactly one edge after its stimulus. A threshold write affects the pause decision one edge later still, because the decision at the write edge uses the old threshold. The bench drives inputs on falling edges and updates its integer model on rising edges. On every falling edge it compares all counts and pause outputs with that model. Directed checks sampled on the falling edge right after each stimulus confirm the expected values of the corner cases.

// File: rtl/rx_fc_pkg.sv
package rx_fc_pkg;
  localparam int DATA_W      = 32;
  localparam int CFG_ADDR    = 0;
  localparam int GRP_BASE    = 4;
  localparam int GRP_STRIDE  = 12;
  localparam int LO_OFS      = 0;
  localparam int HI_OFS      = 4;
  localparam int ALLOC_OFS   = 8;
  localparam int FORCE_BIT   = 31;
  localparam int ALLOC_W     = 16;

  function automatic int grp_reg_addr(int grp, int ofs);
    return GRP_BASE + GRP_STRIDE * grp + ofs;
  endfunction
endpackage

// File: rtl/rx_fc_regs.sv
module rx_fc_regs
  import rx_fc_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic                            ctrl_en,
  output logic [NUM_GRP-1:0]              grp_en,
  output logic [NUM_GRP-1:0][CNT_W-1:0]   lo_thr,
  output logic [NUM_GRP-1:0][CNT_W-1:0]   hi_thr,
  output logic [NUM_GRP-1:0]              alloc_we,
  output logic                            alloc_force,
  output logic [ALLOC_W-1:0]              alloc_amt
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  logic cfg_hit;
  logic unused_data;

  assign cfg_hit     = wr_en && (wr_addr == CFG_A);
  assign alloc_force = wr_data[FORCE_BIT];
  assign alloc_amt   = wr_data[ALLOC_W-1:0];
  assign unused_data = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      grp_en  <= '0;
    end else if (cfg_hit) begin
      ctrl_en <= wr_data[0];
      grp_en  <= wr_data[NUM_GRP:1];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(grp_reg_addr(g, LO_OFS));
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(grp_reg_addr(g, HI_OFS));
    localparam logic [ADDR_W-1:0] AL_A = ADDR_W'(grp_reg_addr(g, ALLOC_OFS));

    logic lo_hit, hi_hit;
    assign lo_hit      = wr_en && (wr_addr == LO_A);
    assign hi_hit      = wr_en && (wr_addr == HI_A);
    assign alloc_we[g] = wr_en && (wr_addr == AL_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_thr[g] <= '0;
        hi_thr[g] <= '0;
      end else begin
        if (lo_hit) lo_thr[g] <= wr_data[CNT_W-1:0];
        if (hi_hit) hi_thr[g] <= wr_data[CNT_W-1:0];
      end
    end
  end

  // R2: a single write can reach at most one allocation register
  p_alloc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_we));
endmodule

// File: rtl/rx_fc_group.sv
module rx_fc_group
  import rx_fc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_we,
  input  logic               alloc_force,
  input  logic [ALLOC_W-1:0] alloc_amt,
  input  logic               consume_i,
  input  logic               count_en_i,
  input  logic [CNT_W-1:0]   lo_i,
  input  logic [CNT_W-1:0]   hi_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               pause_o
);
  localparam int SUM_W = ((CNT_W > ALLOC_W) ? CNT_W : ALLOC_W) + 1;
  localparam logic [SUM_W-1:0] MAX_S = SUM_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'((1 << CNT_W) - 1);

  logic             force_q, force_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pause_q, pause_d;
  logic [SUM_W-1:0] add_s, sum_s, diff_s;
  logic             dec;

  always_comb begin
    force_d = alloc_we ? alloc_force : force_q;
    add_s   = (alloc_we && !alloc_force) ? SUM_W'(alloc_amt) : '0;
    sum_s   = SUM_W'(cnt_q) + add_s;
    dec     = consume_i && count_en_i && !force_d && (sum_s != '0);
    diff_s  = sum_s - SUM_W'(dec);
    if (force_d)             cnt_d = '0;
    else if (diff_s > MAX_S) cnt_d = MAX_C;
    else                     cnt_d = diff_s[CNT_W-1:0];
  end

  always_comb begin
    if (force_d)           pause_d = 1'b0;
    else if (cnt_d < lo_i) pause_d = 1'b1;
    else if (cnt_d >= hi_i) pause_d = 1'b0;
    else                   pause_d = pause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      cnt_q   <= '0;
      pause_q <= 1'b0;
    end else begin
      force_q <= force_d;
      cnt_q   <= cnt_d;
      pause_q <= pause_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign pause_o = pause_q;

  // R4: adding to a full count keeps it full
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_C && alloc_we && !alloc_force && !consume_i) |=> cnt_q == MAX_C);
  // R5: an empty count with nothing added stays empty
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !alloc_we) |=> cnt_q == '0);
  // R5: a lone consume removes exactly one credit
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_we && consume_i && count_en_i && !force_q && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R8: a forced group is parked at zero with no pause
  p_force_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> (cnt_q == '0 && !pause_q));
  // R7: pause only turns on with the count under the low threshold
  p_pause_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_q) |-> cnt_q < $past(lo_i));
  // R7: pause only turns off at or above the high threshold, or when forced
  p_pause_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_q) |-> (force_q || cnt_q >= $past(hi_i)));
endmodule

// File: rtl/rx_fc_credit_tracker.sv
module rx_fc_credit_tracker
  import rx_fc_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_GRP-1:0]       consume,
  output logic [NUM_GRP-1:0]       pause,
  output logic [NUM_GRP*CNT_W-1:0] credits
);
  logic                          ctrl_en;
  logic [NUM_GRP-1:0]            grp_en;
  logic [NUM_GRP-1:0][CNT_W-1:0] lo_thr, hi_thr;
  logic [NUM_GRP-1:0]            alloc_we;
  logic                          alloc_force;
  logic [ALLOC_W-1:0]            alloc_amt;
  logic [NUM_GRP-1:0]            pause_st;

  rx_fc_regs #(.NUM_GRP(NUM_GRP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_en(ctrl_en), .grp_en(grp_en), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .alloc_we(alloc_we), .alloc_force(alloc_force), .alloc_amt(alloc_amt)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    rx_fc_group #(.CNT_W(CNT_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .alloc_we(alloc_we[g]), .alloc_force(alloc_force), .alloc_amt(alloc_amt),
      .consume_i(consume[g]), .count_en_i(ctrl_en),
      .lo_i(lo_thr[g]), .hi_i(hi_thr[g]),
      .cnt_o(credits[g*CNT_W +: CNT_W]), .pause_o(pause_st[g])
    );

    assign pause[g] = pause_st[g] && ctrl_en && grp_en[g];

    // R9: an output pause needs both enables
    p_pause_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pause[g] |-> (ctrl_en && grp_en[g]));
  end
endmodule

// File: tb/rx_fc_credit_tracker_bench.sv
module rx_fc_credit_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [NG-1:0]     consume = '0;
  logic [NG-1:0]     pause;
  logic [NG*CW-1:0]  credits;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cnt[NG], m_lo[NG], m_hi[NG];
  bit m_pause[NG], m_force[NG], m_fen[NG];
  bit m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fc_credit_tracker u_rx_fc_credit_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .consume(consume), .pause(pause), .credits(credits)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cred(int g);
    return int'(credits[g*CW +: CW]);
  endfunction

  // behavioural model
  initial begin
    for (int g = 0; g < NG; g++) begin
      m_cnt[g] = 0; m_lo[g] = 0; m_hi[g] = 0;
      m_pause[g] = 0; m_force[g] = 0; m_fen[g] = 0;
    end
    m_ctrl = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        m_cnt[g] = 0; m_lo[g] = 0; m_hi[g] = 0;
        m_pause[g] = 0; m_force[g] = 0; m_fen[g] = 0;
      end
      m_ctrl = 0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        int add, t;
        add = 0;
        if (wr_en && int'(wr_addr) == 12 + 12*g) begin
          if (wr_data[31]) m_force[g] = 1;
          else begin m_force[g] = 0; add = int'(wr_data[15:0]); end
        end
        if (m_force[g]) begin
          m_cnt[g] = 0; m_pause[g] = 0;
        end else begin
          t = m_cnt[g] + add;
          if (consume[g] && m_ctrl && t > 0) t = t - 1;
          if (t > MAXC) t = MAXC;
          m_cnt[g] = t;
          if (t < m_lo[g]) m_pause[g] = 1;
          else if (t >= m_hi[g]) m_pause[g] = 0;
        end
      end
      if (wr_en) begin
        for (int g = 0; g < NG; g++) begin
          if (int'(wr_addr) == 4 + 12*g) m_lo[g] = int'(wr_data[CW-1:0]);
          if (int'(wr_addr) == 8 + 12*g) m_hi[g] = int'(wr_data[CW-1:0]);
        end
        if (wr_addr == 8'h00) begin
          m_ctrl = wr_data[0];
          for (int g = 0; g < NG; g++) m_fen[g] = wr_data[g+1];
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      for (int g = 0; g < NG; g++) begin
        chk(cur_req, $sformatf("model credits g%0d", g), cred(g), m_cnt[g]);
        chk(cur_req, $sformatf("model pause g%0d", g), int'(pause[g]),
            int'(m_pause[g] && m_ctrl && m_fen[g]));
      end
    end
  end

  task automatic wr(int addr, logic [31:0] data);
    wr_en = 1'b1; wr_addr = 8'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic eat(int g, int n);
    for (int i = 0; i < n; i++) begin
      consume[g] = 1'b1;
      @(negedge clk);
      consume[g] = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    cur_req = "R1";
    for (int g = 0; g < NG; g++) begin
      chk("R1", "reset credits", cred(g), 0);
      chk("R1", "reset pause", int'(pause[g]), 0);
    end

    cur_req = "R2";
    wr(0, 32'h1F);
    wr(32'h04, 2);
    wr(32'h08, 4);
    chk("R7", "pause set below low threshold", int'(pause[0]), 1);

    cur_req = "R3";
    wr(32'h0C, 5);
    chk("R3", "credits after alloc", cred(0), 5);
    chk("R7", "pause cleared at high", int'(pause[0]), 0);

    cur_req = "R7";
    eat(0, 3);
    chk("R5", "credits after 3 consumes", cred(0), 2);
    chk("R7", "pause held between thresholds", int'(pause[0]), 0);
    eat(0, 1);
    chk("R7", "pause set at 1", int'(pause[0]), 1);
    wr(32'h0C, 1);
    chk("R7", "pause held at 2", int'(pause[0]), 1);
    wr(32'h0C, 2);
    chk("R7", "pause cleared at 4", int'(pause[0]), 0);

    cur_req = "R5";
    eat(0, 4);
    chk("R5", "credits drained", cred(0), 0);
    eat(0, 2);
    chk("R5", "consume at zero ignored", cred(0), 0);

    cur_req = "R4";
    wr(32'h0C, 300);
    chk("R4", "saturated credits", cred(0), MAXC);
    wr(32'h0C, 1);
    chk("R4", "still saturated", cred(0), MAXC);

    cur_req = "R8";
    wr(32'h0C, 32'h8000_0000);
    chk("R8", "forced credits", cred(0), 0);
    chk("R8", "forced pause", int'(pause[0]), 0);
    eat(0, 1);
    wr(32'h0C, 32'h8000_0007);
    chk("R8", "force holds zero", cred(0), 0);
    wr(32'h0C, 3);
    chk("R8", "release adds amount", cred(0), 3);

    cur_req = "R6";
    consume[0] = 1'b1;
    wr(32'h0C, 4);
    consume[0] = 1'b0;
    chk("R6", "alloc and consume together", cred(0), 6);

    cur_req = "R9";
    eat(0, 5);
    chk("R9", "pause on at 1", int'(pause[0]), 1);
    wr(0, 32'h1D);
    chk("R9", "group disable masks pause", int'(pause[0]), 0);
    chk("R9", "count kept while disabled", cred(0), 1);
    wr(0, 32'h1F);
    chk("R9", "pause back after enable", int'(pause[0]), 1);

    cur_req = "R10";
    wr(0, 32'h1E);
    chk("R10", "controller off masks pause", int'(pause[0]), 0);
    eat(0, 1);
    chk("R10", "consume ignored while off", cred(0), 1);
    wr(0, 32'h1F);

    cur_req = "R11";
    wr(32'h1C, 1);
    wr(32'h20, 3);
    wr(32'h24, 2);
    chk("R11", "group 2 credits", cred(2), 2);
    chk("R11", "group 2 pause held", int'(pause[2]), 1);
    chk("R11", "group 0 untouched", cred(0), 1);
    chk("R11", "group 1 untouched", cred(1), 0);
    eat(2, 1);
    chk("R11", "group 2 consume", cred(2), 1);
    chk("R11", "group 3 untouched", cred(3), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule